// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block chooses one interrupt among a bank of sources and presents it to a processor. Each source holds a pending flag, an enable bit, a 3-bit group level and a 2-bit tie-break level. The group level decides whether the chosen source may interrupt the processor. It is compared with the processor's current level, which the block receives as an input. The tie-break level only orders sources that are pending at the same group level, so it never lets one source preempt another. A group level of zero removes a source from both interrupt and wake-up.

Software reaches the flags, the enables and the packed level words through a small register port. Each register can be written outright, have bits set, or have bits cleared. Hardware event pulses set flags directly. A flag stays set until software clears it. While it stays set above the processor level, the request returns every time the level drops, which gives a recursive interrupt. The chosen vector, its group level, the request and a wake-up indication are registered outputs.

Top module: `prio_intc`

## Requirements
- R1: A source whose group level is 0 never contributes to `irq_req` or `wake`. When no source is eligible, `irq_req`, `irq_vec`, `irq_lvl` and `wake` are all 0.
- R2: `irq_req` is 1 only when the winning source's group level is strictly greater than `cpu_lvl`. `irq_lvl` and `irq_vec` give the winner's group level and index whenever any source is eligible, including when the winner is masked.
- R3: Among eligible sources (flag set, enable set, group level non-zero), the one with the highest group level wins, whatever the tie-break levels are.
- R4: Among eligible sources with equal group level, the one with the higher tie-break level wins.
- R5: When group level and tie-break level are both equal, the source with the lowest index wins.
- R6: A flag stays set until a register write clears it. The request drops when `cpu_lvl` is raised to the winner's level and returns when `cpu_lvl` is lowered again.
- R7: `wr_addr` is {register index, op}, with op in bits [1:0]. Op 0 writes the value, op 1 sets the bits that are 1 in `wr_data`, op 2 clears the bits that are 1 in `wr_data`, and op 3 has no effect. Index 0 holds the flags (bit i = source i), index 1 holds the enables, and index 2+w holds level word w. `rd_data` returns the register selected by `rd_idx` one clock later.
- R8: Level word w gives source 4w+k the 8-bit lane [8k+7:8k]. Within a lane, bits [1:0] are the tie-break level, bits [4:2] are the group level, and bits [7:5] always read 0.
- R9: `wake` is 1 whenever some source has its flag set, its enable set and a non-zero group level, even if `cpu_lvl` masks it.
- R10: The outputs are registered. They reflect a change of `cpu_lvl` at the next clock edge, and a register write at the edge after the edge that performs the write.
- R11: A pulse on `src_evt[i]` sets flag i. If the same cycle also has a software write that clears that flag, the event wins.
- R12: A source whose enable bit is 0 never contributes to `irq_req` or `wake`.
- R13: After reset all flags, enables and level words are 0, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | {register index, op} |
| wr_data | input | 32 | Write value or bit mask |
| src_evt | input | N_SRC | Hardware event pulses, one per source |
| rd_idx | input | IDX_W | Register index to read |
| rd_data | output | 32 | Registered read value |
| cpu_lvl | input | 3 | Current processor interrupt level |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | VEC_W | Index of the winning source |
| irq_lvl | output | 3 | Group level of the winning source |
| wake | output | 1 | Some enabled, pending source has a non-zero group level |

## Verification
Each source is swept alone through every group level against every processor level. This separates the strict comparison from an off-by-one, and shows that level zero is excluded. Pairs of sources, placed in both index orders, go through every combination of group and tie-break levels. The pairs that differ in group level, those that differ only in tie-break level, and those that tie fully show separately that group dominates, that tie-break orders, and that the lower index wins. Directed sequences cover the write, set, clear and no-op register operations, the masked reserved lane bits, the persistent flag with a recursive request, an event colliding with a clear, a masked source that still wakes, and the one-clock output latency.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  typedef logic [2:0] grp_t;
  typedef logic [1:0] sub_t;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_NONE  = 2'd3
  } wr_op_e;

  localparam int          LANE_W    = 8;
  localparam int          LANES     = 4;
  localparam int          WORD_W    = LANE_W * LANES;
  localparam logic [31:0] LANE_MASK = 32'h1F1F_1F1F;

  function automatic logic [31:0] apply_op(input logic [31:0] cur,
                                           input logic [31:0] val,
                                           input wr_op_e op);
    logic [31:0] res;
    case (op)
      OP_WRITE: res = val;
      OP_SET:   res = cur | val;
      OP_CLR:   res = cur & ~val;
      default:  res = cur;
    endcase
    return res;
  endfunction
endpackage

// File: rtl/prio_intc_regs.sv
module prio_intc_regs
  import prio_intc_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int IDX_W = 2,
  localparam int WORDS = N_SRC / LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  wr_op_e            wr_op,
  input  logic [31:0]       wr_data,
  input  logic [N_SRC-1:0]  src_evt,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [31:0]       rd_data,
  output logic [N_SRC-1:0]  flags_o,
  output logic [N_SRC-1:0]  en_o,
  output grp_t              gp_o [N_SRC],
  output sub_t              sp_o [N_SRC]
);
  logic [N_SRC-1:0] flags_q, en_q, flags_d;
  logic [31:0]      flags_ext, en_ext, flags_new, en_new;
  logic [31:0]      lvl_q [WORDS];

  assign flags_ext = 32'(flags_q);
  assign en_ext    = 32'(en_q);
  assign flags_new = apply_op(flags_ext, wr_data, wr_op);
  assign en_new    = apply_op(en_ext, wr_data, wr_op);

  always_comb begin
    flags_d = flags_q;
    if (wr_en && wr_idx == IDX_W'(0))
      flags_d = flags_new[N_SRC-1:0];
    flags_d = flags_d | src_evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      en_q    <= '0;
    end else begin
      flags_q <= flags_d;
      if (wr_en && wr_idx == IDX_W'(1))
        en_q <= en_new[N_SRC-1:0];
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        lvl_q[w] <= '0;
      else if (wr_en && wr_idx == IDX_W'(2 + w))
        lvl_q[w] <= apply_op(lvl_q[w], wr_data, wr_op) & LANE_MASK;
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign gp_o[i] = lvl_q[i / LANES][(i % LANES) * LANE_W + 2 +: 3];
    assign sp_o[i] = lvl_q[i / LANES][(i % LANES) * LANE_W +: 2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      if (rd_idx == IDX_W'(0))
        rd_data <= flags_ext;
      else if (rd_idx == IDX_W'(1))
        rd_data <= en_ext;
      for (int w = 0; w < WORDS; w++)
        if (rd_idx == IDX_W'(2 + w))
          rd_data <= lvl_q[w];
    end
  end

  assign flags_o = flags_q;
  assign en_o    = en_q;
endmodule

// File: rtl/prio_intc_select.sv
module prio_intc_select
  import prio_intc_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int VEC_W = 3
) (
  input  logic [N_SRC-1:0] elig,
  input  grp_t             gp_i [N_SRC],
  input  sub_t             sp_i [N_SRC],
  output logic             found,
  output logic [VEC_W-1:0] win_idx,
  output grp_t             win_gp
);
  logic [4:0] best_key;

  // Ascending scan with a strict compare keeps the lowest index on a full tie.
  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    win_gp   = '0;
    best_key = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!found || {gp_i[i], sp_i[i]} > best_key)) begin
        found    = 1'b1;
        best_key = {gp_i[i], sp_i[i]};
        win_idx  = VEC_W'(i);
        win_gp   = gp_i[i];
      end
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter  int N_SRC   = 8,
  localparam int REG_CNT = 2 + N_SRC / LANES,
  localparam int IDX_W   = (REG_CNT > 1) ? $clog2(REG_CNT) : 1,
  localparam int ADDR_W  = IDX_W + 2,
  localparam int VEC_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [N_SRC-1:0]  src_evt,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [31:0]       rd_data,
  input  logic [2:0]        cpu_lvl,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  output logic [2:0]        irq_lvl,
  output logic              wake
);
  logic [N_SRC-1:0] flags, en, elig;
  grp_t             gp [N_SRC];
  sub_t             sp [N_SRC];
  logic             found;
  logic [VEC_W-1:0] win_idx;
  grp_t             win_gp;

  prio_intc_regs #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_addr[ADDR_W-1:2]),
    .wr_op   (wr_op_e'(wr_addr[1:0])),
    .wr_data (wr_data),
    .src_evt (src_evt),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .flags_o (flags),
    .en_o    (en),
    .gp_o    (gp),
    .sp_o    (sp)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_elig
    assign elig[i] = flags[i] & en[i] & (gp[i] != 3'd0);
  end

  prio_intc_select #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_sel (
    .elig    (elig),
    .gp_i    (gp),
    .sp_i    (sp),
    .found   (found),
    .win_idx (win_idx),
    .win_gp  (win_gp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
      irq_lvl <= '0;
      wake    <= 1'b0;
    end else begin
      irq_req <= found && (win_gp > cpu_lvl);
      irq_vec <= found ? win_idx : '0;
      irq_lvl <= found ? win_gp : 3'd0;
      wake    <= found;
    end
  end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int N_SRC  = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [N_SRC-1:0]  src_evt,
  input logic [2:0]        cpu_lvl,
  input logic              irq_req,
  input logic [2:0]        irq_lvl,
  input logic              wake,
  input logic [N_SRC-1:0]  flags
);
  logic flag_drop_ok;
  assign flag_drop_ok = wr_en && (wr_addr[ADDR_W-1:2] == '0) &&
                        (wr_addr[1:0] == 2'd0 || wr_addr[1:0] == 2'd2);

  a_r2_strictly_above: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_lvl > $past(cpu_lvl)));

  a_r1_req_level_nonzero: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_lvl != 3'd0));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !wake |-> (!irq_req && irq_lvl == 3'd0));

  a_r9_req_implies_wake: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> wake);

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    !flag_drop_ok |=> ((flags & $past(flags)) == $past(flags)));

  a_r11_event_sets: assert property (@(posedge clk) disable iff (rst)
    (src_evt != '0) |=> ((flags & $past(src_evt)) == $past(src_evt)));
endmodule

bind prio_intc prio_intc_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .src_evt (src_evt),
  .cpu_lvl (cpu_lvl),
  .irq_req (irq_req),
  .irq_lvl (irq_lvl),
  .wake    (wake),
  .flags   (flags)
);

// File: tb/prio_intc_test.sv
module prio_intc_test;
  localparam int CLK_P = 10;
  localparam int N     = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [N-1:0] src_evt = '0;
  logic [1:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic [2:0]  cpu_lvl = '0;
  logic        irq_req;
  logic [2:0]  irq_vec;
  logic [2:0]  irq_lvl;
  logic        wake;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_gp [N];
  int m_sp [N];
  int m_flag;
  int m_en;

  always #(CLK_P/2) clk = ~clk;

  prio_intc #(.N_SRC(N)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .src_evt(src_evt), .rd_idx(rd_idx), .rd_data(rd_data), .cpu_lvl(cpu_lvl),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl), .wake(wake)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input int op, input logic [31:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = 4'((idx << 2) | op);
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    @(negedge clk);
    rd_idx = 2'(idx);
    @(posedge clk);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push_levels();
    for (int w = 0; w < 2; w++) begin
      logic [31:0] word = '0;
      for (int k = 0; k < 4; k++)
        word[8*k +: 8] = 8'((m_gp[4*w+k] << 2) | m_sp[4*w+k]);
      wr(2 + w, 0, word);
    end
  endtask

  task automatic expect_out(output int r, output int v, output int l, output int w);
    int bk = -1;
    r = 0; v = 0; l = 0; w = 0;
    for (int i = 0; i < N; i++) begin
      if (m_flag[i] && m_en[i] && m_gp[i] != 0) begin
        int key = m_gp[i] * 4 + m_sp[i];
        if (key > bk) begin
          bk = key; v = i; l = m_gp[i];
        end
      end
    end
    if (bk >= 0) begin
      w = 1;
      r = (l > int'(cpu_lvl)) ? 1 : 0;
    end
  endtask

  task automatic compare_all(input string tag);
    int r, v, l, w;
    expect_out(r, v, l, w);
    check_eq({tag, " irq_req"}, int'(irq_req), r);
    check_eq({tag, " irq_vec"}, int'(irq_vec), v);
    check_eq({tag, " irq_lvl"}, int'(irq_lvl), l);
    check_eq({tag, " wake"}, int'(wake), w);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < N; i++) begin m_gp[i] = 0; m_sp[i] = 0; end
    m_flag = 0; m_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R13 reset state
    check_eq("R13 irq_req", int'(irq_req), 0);
    check_eq("R13 wake", int'(wake), 0);
    check_eq("R13 irq_lvl", int'(irq_lvl), 0);
    for (int i = 0; i < 4; i++) begin
      rd(i, v);
      check_eq("R13 register zero", int'(v), 0);
    end

    // R7 register ops on the flag register (no levels, so no arbitration)
    wr(0, 0, 32'hA5); rd(0, v); check_eq("R7 write", int'(v), 32'hA5);
    wr(0, 1, 32'h0F); rd(0, v); check_eq("R7 set", int'(v), 32'hAF);
    wr(0, 2, 32'h21); rd(0, v); check_eq("R7 clear", int'(v), 32'h8E);
    wr(0, 3, 32'hFF); rd(0, v); check_eq("R7 no-op", int'(v), 32'h8E);
    wr(1, 0, 32'h3C); rd(1, v); check_eq("R7 enable write", int'(v), 32'h3C);
    wr(0, 0, 0); wr(1, 0, 0);
    check_eq("R1 zero levels quiet", int'(wake), 0);

    // R8 lane layout and reserved bits
    wr(2, 0, 32'hFFFF_FFFF); rd(2, v);
    check_eq("R8 reserved bits read zero", int'(v), 32'h1F1F_1F1F);
    wr(2, 0, 0);
    wr(3, 0, 32'h0000_0E00);
    m_gp[5] = 3; m_sp[5] = 2;
    wr(1, 0, 32'hFF); m_en = 32'hFF;
    wr(0, 0, 32'h20); m_flag = 32'h20;
    settle();
    check_eq("R8 lane decode level", int'(irq_lvl), 3);
    check_eq("R8 lane decode vector", int'(irq_vec), 5);
    rd(3, v);
    check_eq("R8 lane readback", int'(v), 32'h0000_0E00);
    m_gp[5] = 0; m_sp[5] = 0; push_levels();
    wr(0, 0, 0); m_flag = 0;

    // R1 R2 R9 single-source sweep
    for (int s = 0; s < N; s++) begin
      wr(0, 0, 32'(1 << s)); m_flag = 1 << s;
      for (int g = 0; g < 8; g++) begin
        m_gp[s] = g; m_sp[s] = g % 4;
        push_levels();
        for (int c = 0; c < 8; c++) begin
          @(negedge clk); cpu_lvl = 3'(c);
          settle();
          compare_all(g == 0 ? "R1 single" : (g > c ? "R2 single" : "R9 single"));
        end
      end
      m_gp[s] = 0; m_sp[s] = 0;
    end
    push_levels();
    @(negedge clk); cpu_lvl = 0;

    // R3 R4 R5 pair sweep, both index orders
    for (int p = 0; p < 2; p++) begin
      int a = (p == 0) ? 2 : 6;
      int b = (p == 0) ? 5 : 1;
      wr(0, 0, 32'((1 << a) | (1 << b))); m_flag = (1 << a) | (1 << b);
      for (int ga = 1; ga < 8; ga++)
        for (int gb = 1; gb < 8; gb++)
          for (int sa = 0; sa < 4; sa++)
            for (int sb = 0; sb < 4; sb++) begin
              m_gp[a] = ga; m_sp[a] = sa; m_gp[b] = gb; m_sp[b] = sb;
              push_levels();
              settle();
              compare_all(ga != gb ? "R3 pair" : (sa != sb ? "R4 pair" : "R5 pair"));
            end
      m_gp[a] = 0; m_sp[a] = 0; m_gp[b] = 0; m_sp[b] = 0;
    end
    push_levels();

    // R12 enable off hides the source
    m_gp[4] = 6; push_levels();
    wr(0, 0, 32'h10); m_flag = 32'h10;
    wr(1, 2, 32'h10); m_en = 32'hEF;
    settle();
    check_eq("R12 disabled req", int'(irq_req), 0);
    check_eq("R12 disabled wake", int'(wake), 0);
    wr(1, 1, 32'h10); m_en = 32'hFF;

    // R9 masked source still wakes
    @(negedge clk); cpu_lvl = 3'd6;
    settle();
    check_eq("R9 masked req", int'(irq_req), 0);
    check_eq("R9 masked wake", int'(wake), 1);
    check_eq("R2 masked level", int'(irq_lvl), 6);

    // R10 latency of cpu_lvl
    @(negedge clk); cpu_lvl = 3'd2;
    @(posedge clk); @(negedge clk);
    check_eq("R10 level one clock", int'(irq_req), 1);

    // R6 sticky flag and recursive request
    repeat (10) @(posedge clk);
    @(negedge clk);
    check_eq("R6 request held", int'(irq_req), 1);
    @(negedge clk); cpu_lvl = 3'd6;
    settle();
    check_eq("R6 masked at own level", int'(irq_req), 0);
    rd(0, v);
    check_eq("R6 flag still set", int'(v), 32'h10);
    @(negedge clk); cpu_lvl = 3'd1;
    settle();
    check_eq("R6 recursive request", int'(irq_req), 1);

    // R10 latency of a register write
    wr(0, 2, 32'h10); m_flag = 0;
    check_eq("R10 write not yet visible", int'(irq_req), 1);
    @(posedge clk); @(negedge clk);
    check_eq("R10 write visible next clock", int'(irq_req), 0);

    // R11 event beats a same-cycle clear
    m_gp[3] = 2; push_levels();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'((0 << 2) | 2); wr_data = 32'h08;
    src_evt = 8'h08;
    @(negedge clk);
    wr_en = 1'b0; src_evt = '0;
    rd(0, v);
    check_eq("R11 event wins over clear", int'(v), 32'h08);
    m_flag = 32'h08;
    settle();
    compare_all("R11 event request");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule